// File: doc/BRIEF.md
# Watchdog Timer with Two-Byte Feed Sequence

The block is a watchdog peripheral split across two clocks. A simple register bus runs on the bus clock. Software uses it to program a timeout constant and a mode, and to read back the live counter. A down-counter runs on a separate watchdog clock. Once the watchdog is enabled, the counter decrements on every watchdog-clock edge. When it would pass below zero, it reloads from the timeout constant and records a timeout.

Software keeps the watchdog quiet by writing a key pair to the feed register. The pair is 0xAA, then 0x55 as the very next bus write. A completed pair reloads the counter and also commits any pending mode bits. The enable and reset-mode bits are sticky: a feed can set them, and only a system reset clears them. On timeout, a sticky flag is raised. The flag drives a reset request when reset mode is active, or an interrupt otherwise.

Configuration crosses to the watchdog clock through toggle synchronisers. The counter value crosses back through a capture register guarded by a request/acknowledge toggle loop.

Top module: `wdt_top`

## Requirements
- R1: After reset, the mode register reads 0, and the timeout constant and counter value registers both read 0xFF.
- R2: Register layout, using byte addresses on `bus_addr`:
  - 0x0 is the mode register: bit0 enable, bit1 reset mode, bit2 timeout flag.
  - 0x4 is the timeout constant, read/write, CW bits.
  - 0x8 is the feed register. It is write-only and reads 0.
  - 0xC is the counter value, read-only.
- R3: The counter reloads from the timeout constant only when a feed write of 0xAA is directly followed by a feed write of 0x55. Any other bus write in between aborts the pair. A repeated 0xAA re-arms the pair.
- R4: Mode bits written to bit0/bit1 take effect, and become visible on read, only when a valid feed pair completes.
- R5: Once set, the enable and reset-mode bits cannot be cleared by any bus write.
- R6: While disabled, the counter holds its value. While enabled, it decrements once per watchdog-clock edge.
- R7: When the counter is at 0 on an enabled edge, it reloads from the timeout constant and the timeout flag sets. A mode write with bit2=0 clears the flag. A mode write with bit2=1 leaves it unchanged. Feeding often enough keeps the flag clear.
- R8: With the flag set, `wdt_rst_req` is high in reset mode and `wdt_irq` is high in interrupt mode. The two are never high together.
- R9: Timeout constant writes and feed reloads reach the watchdog-clock logic on the third watchdog-clock edge after the bus write.
- R10: The counter value is captured in the watchdog-clock domain and is held stable while it crosses to the bus clock, so a read never returns a torn value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock |
| brst_n | input | 1 | Bus-domain asynchronous active-low reset |
| wclk | input | 1 | Watchdog counting clock |
| wrst_n | input | 1 | Watchdog-domain asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Combinational read data for `bus_addr` |
| wdt_rst_req | output | 1 | Timeout in reset mode |
| wdt_irq | output | 1 | Timeout in interrupt mode |

## Verification
The assertions assume that software leaves the timeout constant alone while a feed is crossing into the watchdog clock. They also assume that each bus write is a single-cycle strobe. The stimulus respects both: every write is one cycle wide, and every feed pair is followed by a wait of several watchdog cycles before the constant is touched again. The random phase runs with the watchdog disabled. The counter is then frozen, so whether a random run of feed bytes and interleaved writes caused a reload can be read back exactly.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned AW = 4;
  localparam logic [AW-1:0] OFS_MODE = 4'h0;
  localparam logic [AW-1:0] OFS_TC   = 4'h4;
  localparam logic [AW-1:0] OFS_FEED = 4'h8;
  localparam logic [AW-1:0] OFS_CNT  = 4'hC;
  localparam logic [7:0] KEY_ARM  = 8'hAA;
  localparam logic [7:0] KEY_FIRE = 8'h55;
  localparam int MB_EN  = 0;
  localparam int MB_RM  = 1;
  localparam int MB_TOF = 2;
  typedef enum logic {FD_IDLE, FD_ARMED} feed_st_t;
endpackage

// File: rtl/wdt_tsync.sv
module wdt_tsync (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_i,
  output logic pulse_o
);
  logic [2:0] s_q;
  logic [2:0] s_d;

  always_comb s_d = {s_q[1:0], tgl_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_q <= '0;
    else        s_q <= s_d;
  end

  // change seen on the synchronised toggle -> one-cycle pulse
  assign pulse_o = s_q[1] ^ s_q[2];
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned CW = 16,
  parameter int unsigned DW = 32,
  parameter logic [CW-1:0] TC_RST = 'hFF
) (
  input  logic          bclk,
  input  logic          brst_n,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          uf_pulse_i,
  input  logic          rb_pulse_i,
  input  logic [CW-1:0] rb_data_i,
  output logic [CW-1:0] tc_o,
  output logic          en_o,
  output logic          rm_o,
  output logic          tof_o,
  output logic          cfg_tgl_o,
  output logic          feed_tgl_o,
  output logic          rb_req_o
);
  feed_st_t      fd_q, fd_d;
  logic [CW-1:0] tc_q, tc_d, rd_q, rd_d;
  logic          shd_en_q, shd_en_d, shd_rm_q, shd_rm_d;
  logic          en_q, en_d, rm_q, rm_d, tof_q, tof_d;
  logic          cfg_q, cfg_d, feed_q, feed_d, req_q, req_d;
  logic          wr_mode, wr_tc, wr_feed, feed_ok;

  assign wr_mode = wr_i && (addr_i == OFS_MODE);
  assign wr_tc   = wr_i && (addr_i == OFS_TC);
  assign wr_feed = wr_i && (addr_i == OFS_FEED);

  always_comb begin
    fd_d    = fd_q;
    feed_ok = 1'b0;
    if (wr_feed) begin
      if (fd_q == FD_ARMED && wdata_i[7:0] == KEY_FIRE) begin
        feed_ok = 1'b1;
        fd_d    = FD_IDLE;
      end else begin
        fd_d = (wdata_i[7:0] == KEY_ARM) ? FD_ARMED : FD_IDLE;
      end
    end else if (wr_i) begin
      fd_d = FD_IDLE;
    end
  end

  always_comb begin
    tc_d     = wr_tc ? wdata_i : tc_q;
    cfg_d    = cfg_q ^ wr_tc;
    shd_en_d = wr_mode ? wdata_i[MB_EN] : shd_en_q;
    shd_rm_d = wr_mode ? wdata_i[MB_RM] : shd_rm_q;
    en_d     = en_q | (feed_ok & shd_en_q);
    rm_d     = rm_q | (feed_ok & shd_rm_q);
    feed_d   = feed_q ^ feed_ok;
    tof_d    = tof_q;
    if (uf_pulse_i)                      tof_d = 1'b1;
    else if (wr_mode && !wdata_i[MB_TOF]) tof_d = 1'b0;
    rd_d  = rb_pulse_i ? rb_data_i : rd_q;
    req_d = req_q ^ rb_pulse_i;
  end

  always_ff @(posedge bclk or negedge brst_n) begin
    if (!brst_n) begin
      fd_q     <= FD_IDLE;
      tc_q     <= TC_RST;
      rd_q     <= TC_RST;
      shd_en_q <= 1'b0;
      shd_rm_q <= 1'b0;
      en_q     <= 1'b0;
      rm_q     <= 1'b0;
      tof_q    <= 1'b0;
      cfg_q    <= 1'b0;
      feed_q   <= 1'b0;
      req_q    <= 1'b1;
    end else begin
      fd_q     <= fd_d;
      tc_q     <= tc_d;
      rd_q     <= rd_d;
      shd_en_q <= shd_en_d;
      shd_rm_q <= shd_rm_d;
      en_q     <= en_d;
      rm_q     <= rm_d;
      tof_q    <= tof_d;
      cfg_q    <= cfg_d;
      feed_q   <= feed_d;
      req_q    <= req_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_MODE: begin
        rdata_o[MB_EN]  = en_q;
        rdata_o[MB_RM]  = rm_q;
        rdata_o[MB_TOF] = tof_q;
      end
      OFS_TC:  rdata_o[CW-1:0] = tc_q;
      OFS_CNT: rdata_o[CW-1:0] = rd_q;
      default: rdata_o = '0;
    endcase
  end

  assign tc_o       = tc_q;
  assign en_o       = en_q;
  assign rm_o       = rm_q;
  assign tof_o      = tof_q;
  assign cfg_tgl_o  = cfg_q;
  assign feed_tgl_o = feed_q;
  assign rb_req_o   = req_q;
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int unsigned CW = 16,
  parameter logic [CW-1:0] TC_RST = 'hFF
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          cfg_pulse_i,
  input  logic          feed_pulse_i,
  input  logic          rb_pulse_i,
  input  logic [CW-1:0] tc_i,
  input  logic          en_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cap_o,
  output logic          uf_tgl_o,
  output logic          ack_tgl_o
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] cnt_q, cnt_d, tcw_q, tcw_d, cap_q, cap_d;
  logic          en_q, en_d, uf_q, uf_d, ack_q, ack_d, uf;

  always_comb begin
    tcw_d = (cfg_pulse_i || feed_pulse_i) ? tc_i : tcw_q;
    en_d  = feed_pulse_i ? en_i : en_q;
    uf    = 1'b0;
    cnt_d = cnt_q;
    if (feed_pulse_i) begin
      cnt_d = tc_i;
    end else if (en_q) begin
      if (cnt_q == '0) begin
        cnt_d = tcw_q;
        uf    = 1'b1;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
    uf_d  = uf_q ^ uf;
    cap_d = rb_pulse_i ? cnt_q : cap_q;
    ack_d = ack_q ^ rb_pulse_i;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      cnt_q <= TC_RST;
      tcw_q <= TC_RST;
      cap_q <= TC_RST;
      en_q  <= 1'b0;
      uf_q  <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tcw_q <= tcw_d;
      cap_q <= cap_d;
      en_q  <= en_d;
      uf_q  <= uf_d;
      ack_q <= ack_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign cap_o     = cap_q;
  assign uf_tgl_o  = uf_q;
  assign ack_tgl_o = ack_q;
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int unsigned CW = 16,
  parameter int unsigned DW = 32,
  parameter logic [CW-1:0] TC_RST = 'hFF
) (
  input  logic          bclk,
  input  logic          brst_n,
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          wdt_rst_req,
  output logic          wdt_irq
);
  logic [CW-1:0] tc_q, cnt_w, cap_q;
  logic en_act, rm_act, tof;
  logic cfg_tgl, feed_tgl, rb_req, uf_tgl, ack_tgl;
  logic cfg_pulse_w, feed_pulse_w, rb_pulse_w, uf_pulse_b, rb_pulse_b;
  logic unused_wdata;

  assign unused_wdata = ^bus_wdata[DW-1:CW];

  wdt_regs #(.CW(CW), .DW(DW), .TC_RST(TC_RST)) u_regs (
    .bclk(bclk), .brst_n(brst_n), .wr_i(bus_wr), .addr_i(bus_addr),
    .wdata_i(bus_wdata[CW-1:0]), .rdata_o(bus_rdata),
    .uf_pulse_i(uf_pulse_b), .rb_pulse_i(rb_pulse_b), .rb_data_i(cap_q),
    .tc_o(tc_q), .en_o(en_act), .rm_o(rm_act), .tof_o(tof),
    .cfg_tgl_o(cfg_tgl), .feed_tgl_o(feed_tgl), .rb_req_o(rb_req)
  );

  wdt_tsync u_cfg_sync  (.clk(wclk), .rst_n(wrst_n), .tgl_i(cfg_tgl),  .pulse_o(cfg_pulse_w));
  wdt_tsync u_feed_sync (.clk(wclk), .rst_n(wrst_n), .tgl_i(feed_tgl), .pulse_o(feed_pulse_w));
  wdt_tsync u_req_sync  (.clk(wclk), .rst_n(wrst_n), .tgl_i(rb_req),   .pulse_o(rb_pulse_w));
  wdt_tsync u_uf_sync   (.clk(bclk), .rst_n(brst_n), .tgl_i(uf_tgl),   .pulse_o(uf_pulse_b));
  wdt_tsync u_ack_sync  (.clk(bclk), .rst_n(brst_n), .tgl_i(ack_tgl),  .pulse_o(rb_pulse_b));

  wdt_count #(.CW(CW), .TC_RST(TC_RST)) u_count (
    .wclk(wclk), .wrst_n(wrst_n), .cfg_pulse_i(cfg_pulse_w),
    .feed_pulse_i(feed_pulse_w), .rb_pulse_i(rb_pulse_w), .tc_i(tc_q),
    .en_i(en_act), .cnt_o(cnt_w), .cap_o(cap_q), .uf_tgl_o(uf_tgl),
    .ack_tgl_o(ack_tgl)
  );

  assign wdt_rst_req = tof & en_act & rm_act;
  assign wdt_irq     = tof & en_act & ~rm_act;
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk
  import wdt_pkg::*;
#(
  parameter int unsigned CW = 16,
  parameter int unsigned DW = 32
) (
  input logic          bclk,
  input logic          brst_n,
  input logic          wclk,
  input logic          wrst_n,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          en_act,
  input logic          tof,
  input logic          rb_pulse_b,
  input logic [CW-1:0] cap_q,
  input logic          feed_pulse_w,
  input logic [CW-1:0] cnt_w,
  input logic [CW-1:0] tc_q
);
  // R5
  en_sticky_chk: assert property (@(posedge bclk) disable iff (!brst_n)
    en_act |=> en_act);

  // R4
  en_after_feed_chk: assert property (@(posedge bclk) disable iff (!brst_n)
    $rose(en_act) |-> $past(bus_wr && bus_addr == OFS_FEED && bus_wdata[7:0] == KEY_FIRE));

  // R7
  tof_clear_chk: assert property (@(posedge bclk) disable iff (!brst_n)
    $fell(tof) |-> $past(bus_wr && bus_addr == OFS_MODE && !bus_wdata[MB_TOF]));

  // R10
  rb_stable_chk: assert property (@(posedge bclk) disable iff (!brst_n)
    rb_pulse_b |-> $stable(cap_q));

  // R9
  feed_reload_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    feed_pulse_w |=> cnt_w == $past(tc_q));
endmodule

bind wdt_top wdt_chk #(.CW(CW), .DW(DW)) u_chk (
  .bclk(bclk), .brst_n(brst_n), .wclk(wclk), .wrst_n(wrst_n),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .en_act(en_act), .tof(tof), .rb_pulse_b(rb_pulse_b), .cap_q(cap_q),
  .feed_pulse_w(feed_pulse_w), .cnt_w(cnt_w), .tc_q(tc_q)
);

// File: tb/wdt_top_test.sv
`timescale 1ns/1ps
module wdt_top_test;
  localparam int CW = 16;
  localparam int DW = 32;

  logic bclk = 1'b0, wclk = 1'b0, brst_n = 1'b0, wrst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic wdt_rst_req, wdt_irq;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 bclk = ~bclk;
  always #10  wclk = ~wclk;

  wdt_top #(.CW(CW), .DW(DW)) uut (
    .bclk(bclk), .brst_n(brst_n), .wclk(wclk), .wrst_n(wrst_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .wdt_rst_req(wdt_rst_req), .wdt_irq(wdt_irq)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [DW-1:0] d);
    @(negedge bclk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge bclk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [DW-1:0] d);
    @(negedge bclk);
    bus_addr = a;
    #0.5 d = bus_rdata;
  endtask

  task automatic wait_w(input int n);
    repeat (n) @(posedge wclk);
  endtask

  task automatic feed();
    wr(4'h8, 32'hAA);
    wr(4'h8, 32'h55);
  endtask

  // feed-pair model: kind 0=feed 0xAA, 1=feed 0x55, 2=feed byte b, 3=other write
  function automatic bit feed_step(input bit armed, input int kind, input logic [7:0] b,
                                   output bit fired);
    logic [7:0] v;
    fired = 1'b0;
    if (kind == 3) return 1'b0;
    v = (kind == 0) ? 8'hAA : (kind == 1) ? 8'h55 : b;
    if (armed && v == 8'h55) begin
      fired = 1'b1;
      return 1'b0;
    end
    return (v == 8'hAA);
  endfunction

  initial begin
    repeat (150000) @(posedge bclk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] r, v1, v2, v3;
    logic [CW-1:0] exp_cnt, newtc;
    void'($urandom(32'd4711));
    repeat (10) @(negedge bclk);
    brst_n = 1'b1; wrst_n = 1'b1;
    wait_w(20);

    // R1 / R2 reset state and layout
    rd(4'h0, r); chk(r == 0, "R1 mode", r, 0);
    rd(4'h4, r); chk(r == 32'hFF, "R1 tc", r, 32'hFF);
    rd(4'hC, r); chk(r == 32'hFF, "R1 cnt", r, 32'hFF);
    rd(4'h8, r); chk(r == 0, "R2 feed reads 0", r, 0);
    chk(!wdt_irq && !wdt_rst_req, "R1 outputs", {wdt_rst_req, wdt_irq}, 0);

    // R3 random feed sequences while disabled (counter frozen)
    exp_cnt = 16'hFF;
    for (int t = 0; t < 30; t++) begin
      bit armed = 1'b0, fired, any = 1'b0;
      newtc = 16'($urandom_range(1, 16'hFFFF));
      wr(4'h4, {16'h0, newtc});
      for (int k = 0; k < 4; k++) begin
        int kind = $urandom_range(0, 3);
        logic [7:0] b = 8'($urandom_range(0, 255));
        if (kind == 2 && $urandom_range(0, 3) == 0) b = 8'h55;
        armed = feed_step(armed, kind, b, fired);
        any |= fired;
        case (kind)
          0: wr(4'h8, 32'hAA);
          1: wr(4'h8, 32'h55);
          2: wr(4'h8, {24'h0, b});
          default: wr(4'h4, {16'h0, newtc});
        endcase
      end
      if (any) exp_cnt = newtc;
      wait_w(12);
      rd(4'hC, r); chk(r[CW-1:0] == exp_cnt, "R3 random feed", r, exp_cnt);
      rd(4'h4, r); chk(r[CW-1:0] == newtc, "R2 tc readback", r, newtc);
    end

    // R3 re-arm: AA AA 55 reloads
    wr(4'h4, 32'h1234); wr(4'h8, 32'hAA); feed(); wait_w(12);
    rd(4'hC, r); chk(r == 32'h1234, "R3 rearm reload", r, 32'h1234);
    // R3 abort: AA, other write, 55 -> no reload
    wr(4'h4, 32'h0777); wr(4'h8, 32'hAA); wr(4'h0, 32'h0); wr(4'h8, 32'h55); wait_w(12);
    rd(4'hC, r); chk(r == 32'h1234, "R3 abort", r, 32'h1234);

    // R4 mode pending until feed; R6 holds while disabled
    wr(4'h0, 32'h1);
    rd(4'h0, r); chk(r[1:0] == 0, "R4 mode pending", r, 0);
    wait_w(20);
    rd(4'hC, r); chk(r == 32'h1234, "R6 hold disabled", r, 32'h1234);
    feed();
    rd(4'h0, r); chk(r[1:0] == 2'b01, "R4 mode after feed", r, 1);

    // R6 counting rate
    wait_w(10); rd(4'hC, v1);
    wait_w(50); rd(4'hC, v2);
    chk((v1 - v2) >= 45 && (v1 - v2) <= 55, "R6 decrement rate", v1 - v2, 50);

    // R5 sticky enable
    wr(4'h0, 32'h0); feed();
    rd(4'h0, r); chk(r[0] == 1'b1, "R5 enable sticky", r[0], 1);

    // R3 abort while counting, then valid feed
    wait_w(20); rd(4'hC, v1);
    wr(4'h8, 32'hAA); wr(4'h4, 32'h0777); wr(4'h8, 32'h55);
    wait_w(20); rd(4'hC, v2);
    chk(v2 < v1, "R3 abort keeps counting", v2, v1);
    feed(); wait_w(12); rd(4'hC, v3);
    chk(v3 > v2, "R3 valid feed reloads", v3, v2);

    // R7 / R8 interrupt mode timeout
    wr(4'h4, 32'd40); feed();
    wait_w(10);
    rd(4'h0, r); chk(r[2] == 1'b0 && !wdt_irq, "R7 no early timeout", r, 1);
    wait_w(50);
    rd(4'h0, r); chk(r[2] == 1'b1, "R7 timeout flag", r[2], 1);
    chk(wdt_irq && !wdt_rst_req, "R8 irq in interrupt mode", {wdt_rst_req, wdt_irq}, 1);
    wr(4'h0, 32'h5);
    rd(4'h0, r); chk(r[2] == 1'b1, "R7 write 1 keeps flag", r[2], 1);
    wr(4'h0, 32'h1);
    rd(4'h0, r); chk(r[2] == 1'b0 && !wdt_irq, "R7 flag cleared", r, 1);
    for (int i = 0; i < 8; i++) begin
      feed(); wait_w(20);
    end
    rd(4'h0, r); chk(r[2] == 1'b0 && !wdt_irq, "R7 feeding prevents timeout", r, 1);

    // R8 reset mode
    wr(4'h0, 32'h3); feed();
    rd(4'h0, r); chk(r[1:0] == 2'b11, "R4 reset mode committed", r, 3);
    wait_w(60);
    chk(wdt_rst_req && !wdt_irq, "R8 reset request", {wdt_rst_req, wdt_irq}, 2);

    // R9 new constant reaches counter without a feed (used on next underflow)
    wr(4'h4, 32'h300);
    wait_w(60);
    rd(4'hC, r);
    chk(r <= 32'h300 && r > 32'h300 - 80, "R9 constant used after underflow", r, 32'h300);
    rd(4'h0, r); chk(r[0] && r[1], "R5 reset mode sticky", r, 3);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule